// File: doc/BRIEF.md
# Output compare reference generator

This block drives the active-high compare reference of one timer channel. Each cycle it compares the running counter value against an active compare register and, according to a 3-bit mode, holds, sets, clears, toggles, forces or pulse-width-modulates a registered reference level. The count direction decides which side of the compare value counts as active in the two PWM modes.

The compare register is written through a simple write strobe. When preload is off, a write lands in the active register at once. When preload is on, the write lands in a holding register, and an update-event pulse copies it into the active register. A level input can clear the reference while it is high, and in the PWM modes a trigger pulse can force the reference to the level it would take at a compare match.

All inputs are sampled at one clock edge into an evaluation stage, and the reference register takes the result at the next edge. Every effect therefore shows on `ref_o` two rising edges after the inputs that caused it are presented.

Top module: `ocref_gen`

## Requirements
- R1: After reset `ref_o` is 0 and both the active and holding compare registers are 0.
- R2: Every input presented before rising edge k affects `ref_o` only from rising edge k+1 onward. Compare-register writes are used in comparisons from the cycle after the write.
- R3: Mode 3'b000 (frozen) keeps `ref_o` at its previous value whatever the counter does.
- R4: Mode 3'b001 sets `ref_o` to 1 when counter equals compare. Mode 3'b010 sets it to 0 on that match. Otherwise each mode holds the previous value.
- R5: Mode 3'b011 inverts `ref_o` in each evaluated cycle where counter equals compare.
- R6: Mode 3'b100 drives `ref_o` to 0 and mode 3'b101 drives it to 1, whatever the comparison.
- R7: Mode 3'b110 with `dir_down_i`=0 gives 1 when counter < compare and 0 otherwise. With `dir_down_i`=1 it gives 0 when counter > compare and 1 otherwise.
- R8: Mode 3'b111 gives the inverse of the mode 3'b110 level in both directions.
- R9: With `pre_en_i`=0, a write of `cmp_wdata_i` under `cmp_wr_i` replaces the active compare value directly.
- R10: With `pre_en_i`=1, a write changes only the holding register. The active value copies the holding value when `upd_i` pulses, and keeps its old value until then.
- R11: While `clr_en_i`=1 and `clr_i`=1, `ref_o` is 0 in every mode. This overrides R3 to R8 and R12. With `clr_en_i`=0, `clr_i` has no effect.
- R12: In modes 3'b110/3'b111 with `fast_en_i`=1, a `trig_i` pulse forces the level the mode gives at counter == compare: up-count 0/1, down-count 1/0. With `fast_en_i`=0 the trigger has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_i | input | W | Counter value |
| dir_down_i | input | 1 | 1 = counter counts down |
| upd_i | input | 1 | Update-event pulse |
| trig_i | input | 1 | Trigger pulse |
| clr_i | input | 1 | External clear level |
| clr_en_i | input | 1 | Enables clearing by `clr_i` |
| mode_i | input | 3 | Reference mode |
| pre_en_i | input | 1 | Compare preload enable |
| fast_en_i | input | 1 | Trigger-forcing enable in PWM modes |
| cmp_wr_i | input | 1 | Compare write strobe |
| cmp_wdata_i | input | W | Compare write data |
| ref_o | output | 1 | Registered compare reference |

## Verification
Counter values just below, at and just above the compare value are applied in both count directions. This separates strict from non-strict comparison in the PWM modes and tells mode 3'b110 apart from its inverse. The match modes are run with the counter passing the compare value again, and with a non-matching value in between. This shows holding behaviour as distinct from toggling. Preload is checked by writing while the counter sits between the old and new compare values, so the level shows which register is active before and after the update pulse. Clear and trigger are each applied with their enable both on and off, against a level they would visibly change.

// File: rtl/ocref_gen.sv
module ocref_gen #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cnt_i,
  input  logic         dir_down_i,
  input  logic         upd_i,
  input  logic         trig_i,
  input  logic         clr_i,
  input  logic         clr_en_i,
  input  logic [2:0]   mode_i,
  input  logic         pre_en_i,
  input  logic         fast_en_i,
  input  logic         cmp_wr_i,
  input  logic [W-1:0] cmp_wdata_i,
  output logic         ref_o
);
  logic [W-1:0] cmp_act, cmp_hold;
  logic         eq_q, lt_q, gt_q, dn_q, trig_q, clr_q, fast_q;
  logic [2:0]   mode_q;
  logic         pwm_lvl, ref_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_act  <= '0;
      cmp_hold <= '0;
    end else begin
      if (cmp_wr_i) cmp_hold <= cmp_wdata_i;
      if (cmp_wr_i && !pre_en_i) cmp_act <= cmp_wdata_i;
      else if (upd_i && pre_en_i) cmp_act <= cmp_hold;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eq_q <= 1'b0; lt_q <= 1'b0; gt_q <= 1'b0; dn_q <= 1'b0;
      trig_q <= 1'b0; clr_q <= 1'b0; fast_q <= 1'b0; mode_q <= 3'b000;
    end else begin
      eq_q   <= cnt_i == cmp_act;
      lt_q   <= cnt_i < cmp_act;
      gt_q   <= cnt_i > cmp_act;
      dn_q   <= dir_down_i;
      trig_q <= trig_i;
      clr_q  <= clr_en_i && clr_i;
      fast_q <= fast_en_i;
      mode_q <= mode_i;
    end
  end

  assign pwm_lvl = (fast_q && trig_q) ? dn_q : (dn_q ? !gt_q : lt_q);

  always_comb begin
    ref_d = ref_o;
    unique case (mode_q)
      3'b000: ref_d = ref_o;
      3'b001: if (eq_q) ref_d = 1'b1;
      3'b010: if (eq_q) ref_d = 1'b0;
      3'b011: if (eq_q) ref_d = !ref_o;
      3'b100: ref_d = 1'b0;
      3'b101: ref_d = 1'b1;
      3'b110: ref_d = pwm_lvl;
      3'b111: ref_d = !pwm_lvl;
      default: ref_d = ref_o;
    endcase
    if (clr_q) ref_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_o <= 1'b0;
    else        ref_o <= ref_d;
  end
endmodule

module ocref_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] mode_i,
  input logic       clr_i,
  input logic       clr_en_i,
  input logic       ref_o
);
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  a_r11_clear_low: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && $past(clr_en_i && clr_i, 2)) |-> !ref_o);

  a_r6_force_low: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && $past(mode_i == 3'b100, 2)) |-> !ref_o);

  a_r6_force_high: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && $past(mode_i == 3'b101 && !(clr_en_i && clr_i), 2)) |-> ref_o);

  a_r3_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && $past(mode_i == 3'b000 && !(clr_en_i && clr_i), 2)) |-> ref_o == $past(ref_o));
endmodule

bind ocref_gen ocref_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .clr_i(clr_i),
  .clr_en_i(clr_en_i), .ref_o(ref_o)
);

// File: tb/ocref_gen_tb.sv
module ocref_gen_tb;
  localparam int W = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [W-1:0] cnt_i = '0, cmp_wdata_i = '0;
  logic dir_down_i = 0, upd_i = 0, trig_i = 0, clr_i = 0, clr_en_i = 0;
  logic pre_en_i = 0, fast_en_i = 0, cmp_wr_i = 0;
  logic [2:0] mode_i = 3'b000;
  logic ref_o;

  always #2 clk = ~clk;

  ocref_gen #(.W(W)) u_dut (.*);

  typedef struct { logic exp; int due; string tag; } item_t;
  item_t q[$];
  int n_run = 0, n_fail = 0, cyc = 0;
  logic m_ref = 0;
  logic [W-1:0] m_act = '0, m_hold = '0;
  logic [2:0] m_mode = 0;
  logic m_pen = 0, m_cen = 0, m_fen = 0;
  bit done = 0;

  function automatic logic model(logic [2:0] md, logic dn, logic eq, logic lt, logic gt,
                                 logic tg, logic cl, logic prev);
    logic p, r;
    p = (m_fen && tg) ? dn : (dn ? !gt : lt);
    case (md)
      3'b000: r = prev;
      3'b001: r = eq ? 1'b1 : prev;
      3'b010: r = eq ? 1'b0 : prev;
      3'b011: r = eq ? !prev : prev;
      3'b100: r = 1'b0;
      3'b101: r = 1'b1;
      3'b110: r = p;
      default: r = !p;
    endcase
    if (m_cen && cl) r = 1'b0;
    return r;
  endfunction

  task automatic step(input logic [W-1:0] c, input logic dn, input string tag,
                      input logic up = 0, input logic tg = 0, input logic cl = 0,
                      input logic wr = 0, input logic [W-1:0] wd = '0);
    item_t it;
    @(negedge clk);
    cnt_i = c; dir_down_i = dn; upd_i = up; trig_i = tg; clr_i = cl;
    cmp_wr_i = wr; cmp_wdata_i = wd;
    mode_i = m_mode; pre_en_i = m_pen; clr_en_i = m_cen; fast_en_i = m_fen;
    m_ref = model(m_mode, dn, c == m_act, c < m_act, c > m_act, tg, cl, m_ref);
    if (wr) begin
      if (!m_pen) m_act = wd;
      m_hold = wd;
    end else if (up && m_pen) m_act = m_hold;
    if (wr && m_pen && up) m_act = m_act;
    it.exp = m_ref; it.due = cyc + 2; it.tag = tag;
    q.push_back(it);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1;
    while (q.size() > 0 && q[0].due == cyc) begin
      item_t it;
      it = q.pop_front();
      n_run++;
      if (ref_o !== it.exp) begin
        n_fail++;
        $display("FAIL %s: ref_o=%b expected %b (cycle %0d)", it.tag, ref_o, it.exp, cyc);
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    n_run++;
    if (ref_o !== 1'b0) begin n_fail++; $display("FAIL R1: reset ref_o=%b expected 0", ref_o); end
    @(negedge clk); rst_n = 1'b1;

    m_mode = 3'b000; step(5, 0, "R3"); step(6, 0, "R3");
    m_mode = 3'b001; step(0, 0, "R1 compare zero");
    step(3, 0, "R9", 0, 0, 0, 1, 10);
    m_mode = 3'b010; step(9, 0, "R4"); step(10, 0, "R4 R2"); step(11, 0, "R4");
    m_mode = 3'b001; step(10, 0, "R4"); step(12, 0, "R4");
    m_mode = 3'b000; step(10, 0, "R3"); step(3, 0, "R3");
    m_mode = 3'b011; step(8, 0, "R5"); step(10, 0, "R5"); step(11, 0, "R5");
    step(10, 0, "R5"); step(10, 0, "R5");
    m_mode = 3'b100; step(10, 0, "R6"); step(2, 0, "R6");
    m_mode = 3'b101; step(10, 0, "R6"); step(20, 1, "R6");
    m_mode = 3'b110;
    step(9, 0, "R7"); step(10, 0, "R7"); step(11, 0, "R7");
    step(11, 1, "R7"); step(10, 1, "R7"); step(9, 1, "R7");
    m_mode = 3'b111;
    step(9, 0, "R8"); step(10, 0, "R8"); step(11, 0, "R8");
    step(11, 1, "R8"); step(10, 1, "R8"); step(9, 1, "R8");
    m_mode = 3'b110; m_pen = 1;
    step(15, 0, "R10", 0, 0, 0, 1, 20);
    step(15, 0, "R10"); step(15, 0, "R10");
    step(15, 0, "R10", 1); step(15, 0, "R10"); step(19, 0, "R10"); step(20, 0, "R10");
    m_pen = 0;
    step(25, 0, "R9", 0, 0, 0, 1, 30); step(25, 0, "R9"); step(30, 0, "R9");
    m_mode = 3'b101; m_cen = 1;
    step(1, 0, "R11", 0, 0, 1); step(1, 0, "R11", 0, 0, 1); step(1, 0, "R11");
    m_cen = 0; step(1, 0, "R11", 0, 0, 1);
    m_cen = 1; m_mode = 3'b110; step(1, 0, "R11", 0, 0, 1); m_cen = 0;
    m_mode = 3'b111; m_fen = 1;
    step(5, 0, "R12"); step(5, 0, "R12", 0, 1); step(5, 0, "R12");
    m_mode = 3'b110; step(40, 1, "R12"); step(40, 1, "R12", 0, 1); step(5, 0, "R12", 0, 1);
    m_fen = 0; step(40, 1, "R12", 0, 1); step(40, 1, "R12");
    m_mode = 3'b001; m_fen = 1; step(3, 0, "R12", 0, 1);
    m_mode = 3'b000; repeat (4) step(7, 0, "R3");
    repeat (4) @(posedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule